// File: doc/BRIEF.md
# Station Address Shadow Window

This block keeps a 16-byte shadow copy of a network station address record and exposes it to a host as four 32-bit lanes at I/O offsets 0h to Fh. Bytes 0 to 5 carry the 48-bit station address and bytes 6 to 11 are reserved. Bytes 12 and 13 carry a little-endian 16-bit checksum. Bytes 14 and 15 carry a fixed signature value of 57h each. The rest of the controller never consults these bytes; software reads them and copies the address wherever it is needed.

After reset the shadow is filled from a byte stream that stands in for a serial EEPROM reader. The stream is valid/ready. `ld_ready` is high from reset until the sixteenth byte has been accepted. A byte transfers on every clock edge where both `ld_valid` and `ld_ready` are high, and the sender may leave gaps by lowering `ld_valid`. Once all sixteen bytes are in, `ld_ready` stays low, so the source sees permanent back-pressure, and `ld_done` rises.

Host accesses are single-cycle requests on a plain control port. A 2-bit doubleword index and four byte enables select the bytes. Which accesses are legal depends on the `dw_mode` pin, on the direction, and, for writes, on the `wr_en` configuration bit. Host writes change only the shadow. Two status pins check the loaded record: one for the signature and one for the checksum.

Top module: `sa_station_window`

## Requirements
- R1: From reset `ld_ready` is 1 and `ld_done` is 0. Accepted load bytes fill shadow bytes 0, 1, 2 and onward in arrival order. After the 16th accepted byte, `ld_ready` is 0 and `ld_done` is 1, and both stay that way until the next reset.
- R2: While `ld_done` is 0, a host read returns zero data, no host request raises `acc_err`, and host writes leave the shadow unchanged.
- R3: With `dw_mode`=0, a read is legal when `host_be` is one of 0001, 0010, 0100, 1000, 0011 or 1100. Byte lane k of `rd_data` (bits 8k+7:8k) returns shadow byte 4*`host_dw`+k when `host_be[k]` is set, and returns zero otherwise.
- R4: With `dw_mode`=1, a read is legal only when `host_be`=1111. Any narrower read is rejected, including an aligned one.
- R5: With `dw_mode`=0, a write is legal only when `host_be` is 0011 or 1100. With `dw_mode`=1, a write is legal only when `host_be` is 1111. A write with a single byte enable is always rejected. An accepted write stores each enabled lane into its shadow byte.
- R6: A write is rejected when `wr_en` is 0.
- R7: A rejected access, once loading is complete, pulses `acc_err` for one cycle, sets `rd_data` to all ones and leaves the shadow unchanged.
- R8: `sig_ok` is 1 exactly when loading is complete and shadow bytes 14 and 15 both equal 57h.
- R9: `sum_ok` is 1 exactly when loading is complete and the 16-bit sum of shadow bytes 1 to 11, 14 and 15 equals {byte 13, byte 12}.
- R10: `rd_valid`, `rd_data` and `acc_err` are registered. They appear on the clock edge that samples `host_req`, so `rd_valid` is 1 in the cycle after every read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dw_mode | input | 1 | 0: 16-bit word I/O rules, 1: 32-bit doubleword I/O rules |
| wr_en | input | 1 | Configuration bit that permits host writes |
| ld_valid | input | 1 | Load byte valid |
| ld_ready | output | 1 | Load byte accepted this cycle when valid |
| ld_data | input | 8 | Load byte |
| ld_done | output | 1 | All 16 bytes loaded |
| host_req | input | 1 | Host access request, one cycle per access |
| host_we | input | 1 | 1: write, 0: read |
| host_dw | input | 2 | Doubleword index within the window |
| host_be | input | 4 | Byte enables, bit k selects lane k |
| host_wdata | input | 32 | Write data, lane k at bits 8k+7:8k |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| acc_err | output | 1 | One-cycle strobe on a rejected access |
| sig_ok | output | 1 | Signature bytes match 57h |
| sum_ok | output | 1 | Checksum bytes match the computed sum |

## Verification
The legality decoder is tried with every byte-enable shape that matters, in both modes and both directions. These are a single byte, each aligned half, a misaligned middle pair and the full lane. Together they separate the word-mode read rule, the doubleword rule, which rejects aligned halves, and the write rule, which never allows a single byte. Each rejected write is followed by a doubleword read of the same bytes, which shows that the shadow was left unchanged. The load stream is driven with gaps in `ld_valid` and with a host write in the middle of the load, which shows that bytes are placed in order and that early host writes are dropped. The signature and checksum flags are checked after the load, after edits that break the checksum, after a rewrite that restores it, and after a change that breaks only the signature.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int BYTE_W   = 8;
  localparam int LANES    = 4;
  localparam int BUS_W    = BYTE_W * LANES;
  localparam logic [BYTE_W-1:0] SIG_BYTE = 8'h57;
endpackage

// File: rtl/sa_loader.sv
module sa_loader #(
  parameter int NBYTES = 16,
  localparam int IW = $clog2(NBYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  output logic          ld_ready,
  output logic          done,
  output logic          wr_stb,
  output logic [IW-1:0] wr_idx
);
  logic [IW-1:0] idx_q;
  logic          done_q;

  assign ld_ready = !done_q;
  assign done     = done_q;
  assign wr_stb   = ld_valid && !done_q;
  assign wr_idx   = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (wr_stb) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == IW'(NBYTES - 1)) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sa_access_check.sv
module sa_access_check (
  input  logic       dw_mode,
  input  logic       we,
  input  logic       wr_en,
  input  logic [3:0] be,
  output logic       legal
);
  logic half_lo, half_hi, single, full;

  always_comb begin
    half_lo = (be == 4'b0011);
    half_hi = (be == 4'b1100);
    full    = (be == 4'b1111);
    single  = (be == 4'b0001) || (be == 4'b0010) ||
              (be == 4'b0100) || (be == 4'b1000);
    if (we) begin
      legal = wr_en && (dw_mode ? full : (half_lo || half_hi));
    end else begin
      legal = dw_mode ? full : (half_lo || half_hi || single);
    end
  end
endmodule

// File: rtl/sa_integrity.sv
module sa_integrity
  import sa_pkg::*;
#(
  parameter int NBYTES = 16
) (
  input  logic [NBYTES*BYTE_W-1:0] shadow,
  input  logic                     valid,
  output logic                     sig_ok,
  output logic                     sum_ok
);
  localparam int CK_LO  = NBYTES - 4;
  localparam int SIG_LO = NBYTES - 2;

  logic [15:0] sum;
  logic [15:0] stored;

  always_comb begin
    sum = '0;
    for (int k = 1; k < NBYTES; k++) begin
      if (k < CK_LO || k >= SIG_LO) sum = sum + 16'(shadow[k*BYTE_W +: BYTE_W]);
    end
    stored = {shadow[(CK_LO+1)*BYTE_W +: BYTE_W], shadow[CK_LO*BYTE_W +: BYTE_W]};
    sig_ok = valid &&
             (shadow[SIG_LO*BYTE_W +: BYTE_W] == SIG_BYTE) &&
             (shadow[(SIG_LO+1)*BYTE_W +: BYTE_W] == SIG_BYTE);
    sum_ok = valid && (sum == stored);
  end
endmodule

// File: rtl/sa_station_window.sv
module sa_station_window
  import sa_pkg::*;
#(
  parameter int NBYTES = 16,
  localparam int NDW = NBYTES / LANES,
  localparam int DWW = $clog2(NDW),
  localparam int IW  = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dw_mode,
  input  logic              wr_en,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [BYTE_W-1:0] ld_data,
  output logic              ld_done,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [DWW-1:0]    host_dw,
  input  logic [LANES-1:0]  host_be,
  input  logic [BUS_W-1:0]  host_wdata,
  output logic              rd_valid,
  output logic [BUS_W-1:0]  rd_data,
  output logic              acc_err,
  output logic              sig_ok,
  output logic              sum_ok
);
  logic [NBYTES*BYTE_W-1:0] shadow;
  logic                     ld_stb;
  logic [IW-1:0]            ld_idx;
  logic                     legal;
  logic                     host_wr_hit;
  logic [BUS_W-1:0]         rd_word;

  sa_loader #(.NBYTES(NBYTES)) u_load (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .done(ld_done), .wr_stb(ld_stb), .wr_idx(ld_idx)
  );

  sa_access_check u_acc (
    .dw_mode(dw_mode), .we(host_we), .wr_en(wr_en), .be(host_be), .legal(legal)
  );

  sa_integrity #(.NBYTES(NBYTES)) u_integ (
    .shadow(shadow), .valid(ld_done), .sig_ok(sig_ok), .sum_ok(sum_ok)
  );

  assign host_wr_hit = host_req && host_we && legal && ld_done;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam int LANE = i % LANES;
    localparam int DW   = i / LANES;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[i*BYTE_W +: BYTE_W] <= '0;
      end else if (ld_stb && ld_idx == IW'(i)) begin
        shadow[i*BYTE_W +: BYTE_W] <= ld_data;
      end else if (host_wr_hit && host_dw == DWW'(DW) && host_be[LANE]) begin
        shadow[i*BYTE_W +: BYTE_W] <= host_wdata[LANE*BYTE_W +: BYTE_W];
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rd_word[l*BYTE_W +: BYTE_W] = host_be[l] ?
        shadow[(int'(host_dw)*LANES + l)*BYTE_W +: BYTE_W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      acc_err  <= 1'b0;
    end else begin
      rd_valid <= host_req && !host_we;
      acc_err  <= host_req && ld_done && !legal;
      if (host_req) begin
        if (!ld_done)      rd_data <= '0;
        else if (!legal)   rd_data <= '1;
        else if (!host_we) rd_data <= rd_word;
      end
    end
  end
endmodule

// File: rtl/sa_window_chk.sv
module sa_window_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dw_mode,
  input logic       wr_en,
  input logic       ld_ready,
  input logic       ld_done,
  input logic       host_req,
  input logic       host_we,
  input logic [3:0] host_be,
  input logic       rd_valid,
  input logic [31:0] rd_data,
  input logic       acc_err
);
  p_ready_off_when_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> !ld_ready);
  p_done_sticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> ld_done);
  p_quiet_before_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !ld_done) |=> (!acc_err && rd_data == 32'h0));
  p_dw_narrow_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && dw_mode && host_be != 4'hF && ld_done) |=>
      (acc_err && rd_data == 32'hFFFF_FFFF));
  p_byte_write_rejected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && $countones(host_be) == 1 && ld_done) |=> acc_err);
  p_write_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && !wr_en && ld_done) |=> acc_err);
  p_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we) |=> rd_valid);
endmodule

bind sa_station_window sa_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dw_mode(dw_mode), .wr_en(wr_en),
  .ld_ready(ld_ready), .ld_done(ld_done), .host_req(host_req),
  .host_we(host_we), .host_be(host_be), .rd_valid(rd_valid),
  .rd_data(rd_data), .acc_err(acc_err)
);

// File: tb/sim_sa_station_window.sv
module sim_sa_station_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dw_mode = 1'b0, wr_en = 1'b0;
  logic        ld_valid = 1'b0;
  logic [7:0]  ld_data = '0;
  logic        ld_ready, ld_done;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [1:0]  host_dw = '0;
  logic [3:0]  host_be = '0;
  logic [31:0] host_wdata = '0;
  logic        rd_valid, acc_err, sig_ok, sum_ok;
  logic [31:0] rd_data;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  sa_station_window u0 (.*);

  typedef struct packed {
    logic [3:0]  req;
    logic        mode;
    logic        we;
    logic        wen;
    logic [1:0]  dw;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic        exp_err;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{4'd3, 1'b0, 1'b0, 1'b0, 2'd0, 4'b0001, 32'h0, 32'h0000_0010, 1'b0}, // R3 byte
    '{4'd3, 1'b0, 1'b0, 1'b0, 2'd1, 4'b1100, 32'h0, 32'h1716_0000, 1'b0}, // R3 upper half
    '{4'd3, 1'b0, 1'b0, 1'b0, 2'd3, 4'b1000, 32'h0, 32'h5700_0000, 1'b0}, // R3 top byte
    '{4'd7, 1'b0, 1'b0, 1'b0, 2'd2, 4'b0110, 32'h0, 32'hFFFF_FFFF, 1'b1}, // R7 misaligned
    '{4'd4, 1'b1, 1'b0, 1'b0, 2'd2, 4'b1111, 32'h0, 32'h1B1A_1918, 1'b0}, // R4 full
    '{4'd4, 1'b1, 1'b0, 1'b0, 2'd0, 4'b0011, 32'h0, 32'hFFFF_FFFF, 1'b1}, // R4 aligned half
    '{4'd6, 1'b0, 1'b1, 1'b0, 2'd1, 4'b0011, 32'h0000_AAAA, 32'h0, 1'b1}, // R6 disabled
    '{4'd6, 1'b1, 1'b0, 1'b0, 2'd1, 4'b1111, 32'h0, 32'h1716_1514, 1'b0}, // R6 unchanged
    '{4'd5, 1'b0, 1'b1, 1'b1, 2'd1, 4'b0011, 32'h0000_BEEF, 32'h0, 1'b0}, // R5 word write
    '{4'd5, 1'b0, 1'b0, 1'b0, 2'd1, 4'b0011, 32'h0, 32'h0000_BEEF, 1'b0}, // R5 readback
    '{4'd5, 1'b0, 1'b1, 1'b1, 2'd0, 4'b0001, 32'h0000_00CC, 32'h0, 1'b1}, // R5 byte write
    '{4'd5, 1'b1, 1'b1, 1'b1, 2'd0, 4'b0011, 32'h0000_CCCC, 32'h0, 1'b1}, // R5 half in dw
    '{4'd7, 1'b1, 1'b0, 1'b0, 2'd0, 4'b1111, 32'h0, 32'h1312_1110, 1'b0}, // R7 unchanged
    '{4'd5, 1'b1, 1'b1, 1'b1, 2'd2, 4'b1111, 32'h0102_0304, 32'h0, 1'b0}, // R5 dw write
    '{4'd5, 1'b1, 1'b0, 1'b0, 2'd2, 4'b1111, 32'h0, 32'h0102_0304, 1'b0}  // R5 readback
  };

  function automatic logic [7:0] load_byte(input int i);
    case (i)
      12: return 8'hA0;
      13: return 8'h01;
      14, 15: return 8'h57;
      default: return 8'(8'h10 + i);
    endcase
  endfunction

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic m, input logic we, input logic wen,
                        input logic [1:0] dw, input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    dw_mode = m; host_we = we; wr_en = wen; host_dw = dw; host_be = be;
    host_wdata = wd; host_req = 1'b1;
    @(negedge clk);
    host_req = 1'b0;
  endtask

  task automatic load_bytes(input int from, input int to);
    for (int i = from; i < to; i++) begin
      @(negedge clk);
      ld_valid = 1'b1; ld_data = load_byte(i);
      if (i % 3 == 1) begin
        @(negedge clk);
        ld_valid = 1'b0;
      end
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ready/done", {31'h0, ld_ready, ld_done}, {31'h0, 1'b1, 1'b0});
    access(1'b1, 1'b0, 1'b0, 2'd3, 4'b1111, 32'h0);
    check("R2 read before load", {acc_err, rd_data}, 33'h0);
    check("R10 rd_valid", {32'h0, rd_valid}, 33'h1);
    load_bytes(0, 8);
    access(1'b1, 1'b1, 1'b1, 2'd0, 4'b1111, 32'hDEAD_BEEF);
    check("R2 write before load err", {32'h0, acc_err}, 33'h0);
    load_bytes(8, 16);
    check("R1 done after 16", {31'h0, ld_ready, ld_done}, {31'h0, 1'b0, 1'b1});
    access(1'b1, 1'b0, 1'b0, 2'd0, 4'b1111, 32'h0);
    check("R2 early write dropped", {acc_err, rd_data}, {1'b0, 32'h1312_1110});
    access(1'b1, 1'b0, 1'b0, 2'd3, 4'b1111, 32'h0);
    check("R1 last dword order", {acc_err, rd_data}, {1'b0, 32'h5757_01A0});
    check("R8 sig after load", {32'h0, sig_ok}, 33'h1);
    check("R9 sum after load", {32'h0, sum_ok}, 33'h1);

    for (int v = 0; v < NV; v++) begin
      access(TBL[v].mode, TBL[v].we, TBL[v].wen, TBL[v].dw, TBL[v].be, TBL[v].wd);
      if (TBL[v].we)
        check($sformatf("R%0d vec %0d", TBL[v].req, v), {32'h0, acc_err},
              {32'h0, TBL[v].exp_err});
      else begin
        check($sformatf("R%0d vec %0d", TBL[v].req, v), {acc_err, rd_data},
              {TBL[v].exp_err, TBL[v].exp_rd});
        check("R10 rd_valid vec", {32'h0, rd_valid}, 33'h1);
      end
    end

    check("R9 sum broken by edits", {32'h0, sum_ok}, 33'h0);
    access(1'b1, 1'b1, 1'b1, 2'd3, 4'b1111, 32'h5757_02C8);
    check("R9 sum restored", {31'h0, sig_ok, sum_ok}, {31'h0, 1'b1, 1'b1});
    access(1'b1, 1'b1, 1'b1, 2'd3, 4'b1111, 32'h0057_02C8);
    check("R8 sig broken", {31'h0, sig_ok, sum_ok}, {31'h0, 1'b0, 1'b0});
    @(negedge clk);
    check("R7 err one cycle", {32'h0, acc_err}, 33'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule